// File: doc/BRIEF.md
# Aperture Remapping Translation Table

This block maps a window of device-visible byte addresses, the aperture, onto scattered 4 KiB physical pages. Each aperture page owns one 32-bit table entry. Bit 31 of an entry marks the page as mapped. Bits 30:12 give the physical page frame. An entry of zero leaves the page unmapped.

Software fills the table indirectly through a small register port. It first writes a byte address inside the aperture into a select register. It then writes or reads a data register, which stores into or returns the entry that the selected address falls in. A global enable register switches translation on or off. A read of the enable register also serves as a completion barrier, because it is answered only after every earlier write has been applied.

A separate lookup port takes an aperture address. One cycle later it returns either the translated physical address or a fault. Fault cases are a lookup while translation is off, a lookup outside the aperture, and a lookup of an unmapped entry.

Top module: `aperRemapTop`

## Requirements
- R1: After reset, translation is disabled, the select register holds zero, and every table entry holds zero.
- R2: Every register request is acknowledged exactly one cycle later, and read data is valid with that acknowledge. Offsets other than 0x24, 0x28 and 0x2c ignore writes and read as zero.
- R3: Offset 0x24 controls translation. A write stores bit 0 as the enable, and a read returns the enable in bit 0 with zeros elsewhere. A read issued in the cycle right after a write already sees that write.
- R4: Offset 0x28 stores a 32-bit aperture byte address and reads it back unchanged.
- R5: A write to offset 0x2c stores the value into entry (select - APER_BASE) >> 12. A read of offset 0x2c returns that entry's stored value.
- R6: When the select register lies outside the aperture, writes to offset 0x2c change no entry and reads of offset 0x2c return zero.
- R7: One cycle after a lookup request, the valid output rises. When translation is enabled, the address is inside the aperture and entry bit 31 is set, the returned physical address is {1'b0, entry[30:12], addr[11:0]} and no fault is raised.
- R8: A lookup made while translation is disabled faults.
- R9: A lookup below APER_BASE, or at or above APER_BASE + PAGE_COUNT*4096, faults.
- R10: A lookup of an entry whose bit 31 is clear faults, and this includes a zero entry. A faulting lookup returns a physical address of zero.
- R11: When a table write and a lookup of the same entry happen in the same cycle, the lookup returns a result based on the old entry value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regReq | input | 1 | Register request strobe |
| regWe | input | 1 | 1 = write, 0 = read |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regAck | output | 1 | Request acknowledge, one cycle after regReq |
| regRdata | output | 32 | Read data, valid with regAck |
| lkReq | input | 1 | Lookup request |
| lkAddr | input | 32 | Aperture byte address to translate |
| lkValid | output | 1 | Lookup result valid |
| lkPhys | output | 32 | Translated physical address (zero on fault) |
| lkFault | output | 1 | Lookup faulted |

## Verification
A corrupted entry or a wrong index computation shows up at the lookup port on the very next lookup of the affected page. The symptom is a changed frame, a spurious fault, or a hit on a neighbouring page. Reading the entry back through the data register exposes the same fault one cycle after the read request. A stuck enable or a stale select register shows up in the first register read that follows. The bench therefore mixes readback with translation, and probes the first, last and just-outside pages, so that off-by-one range errors appear at once.

// File: rtl/aperRemapPkg.sv
package aperRemapPkg;
  localparam int IDX_MAX_W = 16;
  localparam int PG_SHIFT  = 12;

  localparam logic [7:0] OFS_CFG  = 8'h24;
  localparam logic [7:0] OFS_SEL  = 8'h28;
  localparam logic [7:0] OFS_DATA = 8'h2c;

  typedef struct packed {
    logic                 tblWe;
    logic [IDX_MAX_W-1:0] tblIdx;
    logic [31:0]          tblData;
    logic                 xlateEn;
    logic [IDX_MAX_W-1:0] rdIdx;
  } ctrlStb_t;

  function automatic logic inAper(input logic [31:0] addr, input logic [31:0] base,
                                  input logic [32:0] bytes);
    logic [32:0] off;
    off = {1'b0, addr} - {1'b0, base};
    return (addr >= base) && (off < bytes);
  endfunction
endpackage

// File: rtl/aperRemapCtrl.sv
module aperRemapCtrl
  import aperRemapPkg::*;
#(
  parameter logic [31:0] APER_BASE  = 32'h5800_0000,
  parameter int          PAGE_COUNT = 32,
  parameter int          IDX_W      = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regReq,
  input  logic        regWe,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic        regAck,
  output logic [31:0] regRdata,
  input  logic [31:0] selEntry,
  output ctrlStb_t    stb
);
  localparam logic [32:0] APER_BYTES = 33'(PAGE_COUNT) << PG_SHIFT;

  logic        xlateEn;
  logic [31:0] selAddr;
  logic [32:0] selOff;
  logic        selHit;
  logic [IDX_W-1:0] selIdx;
  logic [31:0] rdMux;

  always_comb begin
    selOff = {1'b0, selAddr} - {1'b0, APER_BASE};
    selHit = inAper(selAddr, APER_BASE, APER_BYTES);
    selIdx = selOff[IDX_W+PG_SHIFT-1:PG_SHIFT];
  end

  always_comb begin
    stb.tblWe   = regReq && regWe && (regAddr == OFS_DATA) && selHit;
    stb.tblIdx  = IDX_MAX_W'(selIdx);
    stb.tblData = regWdata;
    stb.xlateEn = xlateEn;
    stb.rdIdx   = IDX_MAX_W'(selIdx);
  end

  always_comb begin
    unique case (regAddr)
      OFS_CFG:  rdMux = {31'b0, xlateEn};
      OFS_SEL:  rdMux = selAddr;
      OFS_DATA: rdMux = selHit ? selEntry : 32'b0;
      default:  rdMux = 32'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xlateEn  <= 1'b0;
      selAddr  <= 32'b0;
      regAck   <= 1'b0;
      regRdata <= 32'b0;
    end else begin
      regAck   <= regReq;
      regRdata <= (regReq && !regWe) ? rdMux : 32'b0;
      if (regReq && regWe) begin
        if (regAddr == OFS_CFG) xlateEn <= regWdata[0];
        if (regAddr == OFS_SEL) selAddr <= regWdata;
      end
    end
  end
endmodule

// File: rtl/aperRemapDatapath.sv
module aperRemapDatapath
  import aperRemapPkg::*;
#(
  parameter logic [31:0] APER_BASE  = 32'h5800_0000,
  parameter int          PAGE_COUNT = 32,
  parameter int          IDX_W      = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStb_t    stb,
  output logic [31:0] selEntry,
  input  logic        lkReq,
  input  logic [31:0] lkAddr,
  output logic        lkValid,
  output logic [31:0] lkPhys,
  output logic        lkFault
);
  localparam logic [32:0] APER_BYTES = 33'(PAGE_COUNT) << PG_SHIFT;

  logic [31:0] tbl [PAGE_COUNT];
  logic [32:0] lkOff;
  logic        lkHit;
  logic [IDX_W-1:0] lkIdx;
  logic [31:0] lkEntry;
  logic        lkOk;

  genvar g;
  generate
    for (g = 0; g < PAGE_COUNT; g++) begin : gEntry
      always_ff @(posedge clk) begin
        if (!rstN) tbl[g] <= 32'b0;
        else if (stb.tblWe && (stb.tblIdx[IDX_W-1:0] == IDX_W'(g))) tbl[g] <= stb.tblData;
      end
    end
  endgenerate

  assign selEntry = tbl[stb.rdIdx[IDX_W-1:0]];

  always_comb begin
    lkOff   = {1'b0, lkAddr} - {1'b0, APER_BASE};
    lkHit   = inAper(lkAddr, APER_BASE, APER_BYTES);
    lkIdx   = lkOff[IDX_W+PG_SHIFT-1:PG_SHIFT];
    lkEntry = lkHit ? tbl[lkIdx] : 32'b0;
    lkOk    = stb.xlateEn && lkHit && lkEntry[31];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lkValid <= 1'b0;
      lkPhys  <= 32'b0;
      lkFault <= 1'b0;
    end else begin
      lkValid <= lkReq;
      lkFault <= lkReq && !lkOk;
      lkPhys  <= (lkReq && lkOk) ? {1'b0, lkEntry[30:PG_SHIFT], lkAddr[PG_SHIFT-1:0]} : 32'b0;
    end
  end
endmodule

// File: rtl/aperRemapTop.sv
module aperRemapTop
  import aperRemapPkg::*;
#(
  parameter logic [31:0] APER_BASE  = 32'h5800_0000,
  parameter int          PAGE_COUNT = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regReq,
  input  logic        regWe,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic        regAck,
  output logic [31:0] regRdata,
  input  logic        lkReq,
  input  logic [31:0] lkAddr,
  output logic        lkValid,
  output logic [31:0] lkPhys,
  output logic        lkFault
);
  localparam int IDX_W = (PAGE_COUNT < 2) ? 1 : $clog2(PAGE_COUNT);

  ctrlStb_t    stb;
  logic [31:0] selEntry;

  aperRemapCtrl #(.APER_BASE(APER_BASE), .PAGE_COUNT(PAGE_COUNT), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regReq(regReq), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regAck(regAck), .regRdata(regRdata),
    .selEntry(selEntry), .stb(stb)
  );

  aperRemapDatapath #(.APER_BASE(APER_BASE), .PAGE_COUNT(PAGE_COUNT), .IDX_W(IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .selEntry(selEntry),
    .lkReq(lkReq), .lkAddr(lkAddr), .lkValid(lkValid), .lkPhys(lkPhys), .lkFault(lkFault)
  );
endmodule

// File: rtl/aperRemapChk.sv
module aperRemapChk #(
  parameter logic [31:0] APER_BASE  = 32'h5800_0000,
  parameter int          PAGE_COUNT = 32
) (
  input logic        clk,
  input logic        rstN,
  input logic        regReq,
  input logic        regWe,
  input logic [7:0]  regAddr,
  input logic        regAck,
  input logic [31:0] regRdata,
  input logic        lkReq,
  input logic [31:0] lkAddr,
  input logic        lkValid,
  input logic [31:0] lkPhys,
  input logic        lkFault
);
  localparam logic [32:0] APER_END = {1'b0, APER_BASE} + (33'(PAGE_COUNT) << 12);

  logic badOfs;
  logic outside;
  assign badOfs  = (regAddr != 8'h24) && (regAddr != 8'h28) && (regAddr != 8'h2c);
  assign outside = ({1'b0, lkAddr} < {1'b0, APER_BASE}) || ({1'b0, lkAddr} >= APER_END);

  AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rstN) regReq |=> regAck); // R2
  AST_ACK_ONLY: assert property (@(posedge clk) disable iff (!rstN) regAck |-> $past(regReq)); // R2
  AST_BAD_OFS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regWe && badOfs) |=> (regRdata == 32'b0)); // R2
  AST_LK_NEXT: assert property (@(posedge clk) disable iff (!rstN) lkReq |=> lkValid); // R7
  AST_LK_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    (lkReq ##1 (lkValid && !lkFault)) |-> (lkPhys[11:0] == $past(lkAddr[11:0]))); // R7
  AST_RANGE_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (lkReq && outside) |=> lkFault); // R9
  AST_FAULT_PHYS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    lkFault |-> (lkPhys == 32'b0)); // R10
endmodule

bind aperRemapTop aperRemapChk #(.APER_BASE(APER_BASE), .PAGE_COUNT(PAGE_COUNT)) uChk (
  .clk(clk), .rstN(rstN), .regReq(regReq), .regWe(regWe), .regAddr(regAddr),
  .regAck(regAck), .regRdata(regRdata), .lkReq(lkReq), .lkAddr(lkAddr),
  .lkValid(lkValid), .lkPhys(lkPhys), .lkFault(lkFault)
);

// File: tb/sim_aperRemapTop.sv
`timescale 1ns/1ps
module sim_aperRemapTop;
  localparam logic [31:0] BASE = 32'h5800_0000;

  typedef struct packed {
    logic [31:0] addr;
    logic        fault;
    logic [31:0] phys;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h5800_0123, 1'b0, 32'h0001_2123},
    '{32'h5800_5FFF, 1'b0, 32'h0ABC_DFFF},
    '{32'h5801_F004, 1'b0, 32'h7FFF_F004},
    '{32'h5801_FFFF, 1'b0, 32'h7FFF_FFFF},
    '{32'h5800_7010, 1'b1, 32'h0000_0000},
    '{32'h57FF_FFFF, 1'b1, 32'h0000_0000},
    '{32'h5802_0000, 1'b1, 32'h0000_0000},
    '{32'h5800_1000, 1'b1, 32'h0000_0000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regReq = 1'b0, regWe = 1'b0;
  logic [7:0] regAddr = 8'h0;
  logic [31:0] regWdata = 32'h0;
  logic regAck;
  logic [31:0] regRdata;
  logic lkReq = 1'b0;
  logic [31:0] lkAddr = 32'h0;
  logic lkValid, lkFault;
  logic [31:0] lkPhys;

  int nChecks = 0;
  int nErrors = 0;
  int cycles  = 0;

  always #2.5 clk = ~clk;

  aperRemapTop #(.APER_BASE(BASE), .PAGE_COUNT(32)) u0 (
    .clk(clk), .rstN(rstN), .regReq(regReq), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regAck(regAck), .regRdata(regRdata),
    .lkReq(lkReq), .lkAddr(lkAddr), .lkValid(lkValid), .lkPhys(lkPhys), .lkFault(lkFault)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      nErrors = nErrors + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic regWr(input logic [7:0] ofs, input logic [31:0] d);
    @(negedge clk);
    regReq = 1'b1; regWe = 1'b1; regAddr = ofs; regWdata = d;
    @(negedge clk);
    regReq = 1'b0; regWe = 1'b0;
    chk("R2", "write ack", {31'b0, regAck}, 32'd1);
  endtask

  task automatic regRd(input logic [7:0] ofs, output logic [31:0] d);
    @(negedge clk);
    regReq = 1'b1; regWe = 1'b0; regAddr = ofs;
    @(negedge clk);
    regReq = 1'b0;
    d = regRdata;
    if (regAck !== 1'b1) chk("R2", "read ack", {31'b0, regAck}, 32'd1);
  endtask

  task automatic lookup(input logic [31:0] a, output logic f, output logic [31:0] p);
    @(negedge clk);
    lkReq = 1'b1; lkAddr = a;
    @(negedge clk);
    lkReq = 1'b0;
    if (lkValid !== 1'b1) chk("R7", "lookup valid", {31'b0, lkValid}, 32'd1);
    f = lkFault; p = lkPhys;
  endtask

  initial begin
    logic [31:0] d;
    logic f;
    logic [31:0] p;

    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    regRd(8'h24, d); chk("R1", "enable after reset", d, 32'd0);
    regRd(8'h28, d); chk("R1", "select after reset", d, 32'd0);
    regWr(8'h28, BASE + 32'h3000);
    regRd(8'h2c, d); chk("R1", "entry 3 after reset", d, 32'd0);
    regWr(8'h24, 32'd1);
    lookup(BASE + 32'h3000, f, p); chk("R1", "zero entry faults", {31'b0, f}, 32'd1);

    // program table: R5
    regWr(8'h28, BASE + 32'h0000); regWr(8'h2c, 32'h8001_2000);
    regWr(8'h28, BASE + 32'h5ABC); regWr(8'h2c, 32'h8ABC_D000);
    regWr(8'h28, BASE + 32'h1F000); regWr(8'h2c, 32'hFFFF_F000);
    regWr(8'h28, BASE + 32'h7000); regWr(8'h2c, 32'h0003_4000);
    regWr(8'h28, BASE + 32'h5123);
    regRd(8'h28, d); chk("R4", "select readback", d, BASE + 32'h5123);
    regRd(8'h2c, d); chk("R5", "entry 5 readback", d, 32'h8ABC_D000);

    // vector walk: R7, R9, R10
    for (int i = 0; i < 8; i++) begin
      lookup(VECS[i].addr, f, p);
      chk(VECS[i].fault ? "R9/R10" : "R7", "vector fault", {31'b0, f}, {31'b0, VECS[i].fault});
      chk(VECS[i].fault ? "R10" : "R7", "vector phys", p, VECS[i].phys);
    end

    // R6: select outside aperture
    regWr(8'h28, BASE + 32'h20000);
    regWr(8'h2c, 32'h8000_1000);
    regRd(8'h2c, d); chk("R6", "out-of-range data read", d, 32'd0);
    regWr(8'h28, BASE - 32'd4);
    regWr(8'h2c, 32'h8000_2000);
    lookup(BASE + 32'h0010, f, p); chk("R6", "entry 0 untouched", p, 32'h0001_2010);
    regWr(8'h28, BASE + 32'h1000);
    regRd(8'h2c, d); chk("R6", "entry 1 untouched", d, 32'd0);

    // R2: unknown offset
    regWr(8'h30, 32'hFFFF_FFFF);
    regRd(8'h30, d); chk("R2", "unknown offset read", d, 32'd0);
    regRd(8'h24, d); chk("R2", "enable unaffected by unknown write", d, 32'd1);

    // R8: disable
    regWr(8'h24, 32'd0);
    lookup(BASE + 32'h0123, f, p);
    chk("R8", "disabled fault", {31'b0, f}, 32'd1);
    chk("R8", "disabled phys", p, 32'd0);

    // R3: back-to-back write then read of config as barrier
    @(negedge clk);
    regReq = 1'b1; regWe = 1'b1; regAddr = 8'h24; regWdata = 32'hFFFF_FFFF;
    @(negedge clk);
    regWe = 1'b0;
    @(negedge clk);
    regReq = 1'b0;
    chk("R3", "barrier read of enable", regRdata, 32'd1);

    // R10: unmap by writing zero
    regWr(8'h28, BASE + 32'h5000); regWr(8'h2c, 32'd0);
    lookup(BASE + 32'h5004, f, p); chk("R10", "unmapped page faults", {31'b0, f}, 32'd1);

    // R11: same-cycle write and lookup
    regWr(8'h28, BASE + 32'h2000); regWr(8'h2c, 32'h8000_A000);
    @(negedge clk);
    regReq = 1'b1; regWe = 1'b1; regAddr = 8'h2c; regWdata = 32'h8000_B000;
    lkReq = 1'b1; lkAddr = BASE + 32'h2044;
    @(negedge clk);
    regReq = 1'b0; regWe = 1'b0; lkReq = 1'b0;
    chk("R11", "same-cycle lookup uses old entry", lkPhys, 32'h0000_A044);
    lookup(BASE + 32'h2044, f, p); chk("R11", "next lookup uses new entry", p, 32'h0000_B044);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule